// File: doc/BRIEF.md
# Keyed Core Power-Mode Controller

This block holds one 32-bit control register on a simple register bus. The register sets the power state of a secondary processor core. From that state it drives five control signals for the core's domain: power enable, clock enable, isolation, core reset and state retention. A system controller normally programs it while the core is asleep.

To guard against stray writes, the mode field changes only when the upper half of the written word carries an unlock key. On reads, that upper half returns a different fixed constant.

A request for the retained state cannot take effect until the core reports deep sleep. Until then the request waits, and the domain outputs keep their previous values. A done output reports whether the state applied to the domain matches the programmed mode.

Top module: `core_pwr_ctl`

## Requirements
- R1: The mode field is bits [1:0] of the register, encoded as OFF=0, RESET=1, RETAINED=2 and ENABLED=3. A read returns the last accepted mode in those bits.
- R2: A write (bus_we high at the clock edge) updates the mode field only when both of these hold: bus_addr equals REG_ADDR (default 12'h200), and bus_wdata[31:16] equals 16'h05FA. A write with any other key, or to any other address, leaves the register and the domain outputs unchanged.
- R3: bus_rdata is registered and is valid in the cycle after bus_addr is presented. For REG_ADDR it returns 16'hFA05 in bits [31:16], zero in bits [15:2] (whatever was written there) and the mode in bits [1:0]. Any other address reads as zero.
- R4: After reset the register reads 32'hFA050001, the domain outputs show the RESET pattern, and mode_done is high.
- R5: The OFF mode drives power off, clock off, isolation on, core reset on and retention off. In the bench this is written {pwr,clk,iso,rst,ret}=5'b00110.
- R6: The RESET mode drives power on, clock off, isolation off, core reset on and retention off (5'b10010).
- R7: The ENABLED mode drives power on, clock on, isolation off, core reset off and retention off (5'b11000).
- R8: The RETAINED mode drives power off, clock off, isolation on, core reset off and retention on (5'b00101). It is applied only in a cycle where core_deep_sleep is high. Once applied, it stays applied when deep sleep later falls.
- R9: While a RETAINED request waits for deep sleep, the domain outputs hold their previous values and mode_done is low.
- R10: An accepted write of another mode replaces a waiting RETAINED request. The retained pattern then never appears.
- R11: After an accepted write at clock edge k, the domain outputs change at edge k+1. mode_done is low between edges k and k+1 when the new mode differs from the applied one, and otherwise stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Register bus address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data: key in [31:16], mode in [1:0] |
| bus_rdata | output | 32 | Registered read data |
| core_deep_sleep | input | 1 | Core reports deep sleep |
| mode_done | output | 1 | Applied domain state matches the programmed mode |
| dom_pwr_en | output | 1 | Domain power enable |
| dom_clk_en | output | 1 | Domain clock enable |
| dom_iso_en | output | 1 | Domain output isolation |
| dom_rst | output | 1 | Core reset, active high |
| dom_ret_en | output | 1 | State retention enable |

## Verification
Two events can fall in the same cycle: a waiting RETAINED request is released by deep sleep, and a new keyed write selects ENABLED. The bench provokes this by raising core_deep_sleep and issuing the ENABLED write at the same clock edge. The expected result is the retained pattern for exactly one cycle with mode_done low, followed by the enabled pattern with mode_done high. That outcome shows the release was decided on the old programmed mode, and that the write then replaced it one edge later.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  typedef enum logic [1:0] {
    PM_OFF   = 2'd0,
    PM_RESET = 2'd1,
    PM_RET   = 2'd2,
    PM_ON    = 2'd3
  } pmode_e;

  typedef struct packed {
    logic pwr;
    logic clk;
    logic iso;
    logic rst;
    logic ret;
  } dom_t;

  function automatic dom_t dom_of(pmode_e m);
    dom_t d;
    case (m)
      PM_OFF:   d = '{pwr: 1'b0, clk: 1'b0, iso: 1'b1, rst: 1'b1, ret: 1'b0};
      PM_RESET: d = '{pwr: 1'b1, clk: 1'b0, iso: 1'b0, rst: 1'b1, ret: 1'b0};
      PM_RET:   d = '{pwr: 1'b0, clk: 1'b0, iso: 1'b1, rst: 1'b0, ret: 1'b1};
      default:  d = '{pwr: 1'b1, clk: 1'b1, iso: 1'b0, rst: 1'b0, ret: 1'b0};
    endcase
    return d;
  endfunction

endpackage

// File: rtl/pmc_bus_gate.sv
module pmc_bus_gate
  import pmc_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int KEY_W  = 16,
  parameter logic [ADDR_W-1:0] REG_ADDR = 12'h200,
  parameter logic [KEY_W-1:0]  WR_KEY   = 16'h05FA
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [KEY_W-1:0]  key,
  input  logic [1:0]        mode_field,
  output logic              hit,
  output logic              wr_ok,
  output pmode_e            wr_mode
);

  assign hit     = (addr == REG_ADDR);
  assign wr_ok   = we && hit && (key == WR_KEY);
  assign wr_mode = pmode_e'(mode_field);

endmodule

// File: rtl/pmc_mode_reg.sv
module pmc_mode_reg
  import pmc_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   wr_ok,
  input  pmode_e wr_mode,
  output pmode_e prog_mode
);

  always_ff @(posedge clk) begin
    if (rst)        prog_mode <= PM_RESET;
    else if (wr_ok) prog_mode <= wr_mode;
  end

  // R2: the register changes only on an accepted keyed write
  p_keyed_only_r2: assert property (@(posedge clk) disable iff (rst)
    !wr_ok |=> $stable(prog_mode));

endmodule

// File: rtl/pmc_domain_seq.sv
module pmc_domain_seq
  import pmc_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  pmode_e prog_mode,
  input  logic   deep_sleep,
  output pmode_e applied,
  output dom_t   dom,
  output logic   done
);

  pmode_e applied_nxt;

  always_comb begin
    applied_nxt = applied;
    if (prog_mode != PM_RET)  applied_nxt = prog_mode;
    else if (deep_sleep)      applied_nxt = PM_RET;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      applied <= PM_RESET;
      dom     <= dom_of(PM_RESET);
    end else begin
      applied <= applied_nxt;
      dom     <= dom_of(applied_nxt);
    end
  end

  assign done = (applied == prog_mode);

  // R9: a waiting retained request leaves the domain untouched
  p_ret_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (prog_mode == PM_RET && !deep_sleep && applied != PM_RET) |=> $stable(dom));

  // R8: retention only switches on after deep sleep was seen
  p_ret_needs_ds_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(dom.ret) |-> $past(deep_sleep));

  // R5: whenever power is removed the domain is isolated
  p_iso_unpowered_r5: assert property (@(posedge clk) disable iff (rst)
    !dom.pwr |-> dom.iso);

endmodule

// File: rtl/core_pwr_ctl.sv
module core_pwr_ctl
  import pmc_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int KEY_W  = 16,
  parameter logic [ADDR_W-1:0] REG_ADDR = 12'h200,
  parameter logic [KEY_W-1:0]  WR_KEY   = 16'h05FA,
  parameter logic [KEY_W-1:0]  RD_KEY   = 16'hFA05
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              core_deep_sleep,
  output logic              mode_done,
  output logic              dom_pwr_en,
  output logic              dom_clk_en,
  output logic              dom_iso_en,
  output logic              dom_rst,
  output logic              dom_ret_en
);

  localparam int MODE_W = 2;
  localparam int PAD_W  = DATA_W - KEY_W - MODE_W;

  logic   hit, wr_ok;
  pmode_e wr_mode, prog_mode, applied;
  dom_t   dom;
  logic   wdata_pad_unused;

  assign wdata_pad_unused = ^bus_wdata[MODE_W +: PAD_W];

  pmc_bus_gate #(
    .ADDR_W(ADDR_W), .KEY_W(KEY_W), .REG_ADDR(REG_ADDR), .WR_KEY(WR_KEY)
  ) u_gate (
    .addr(bus_addr), .we(bus_we),
    .key(bus_wdata[DATA_W-1 -: KEY_W]),
    .mode_field(bus_wdata[MODE_W-1:0]),
    .hit(hit), .wr_ok(wr_ok), .wr_mode(wr_mode)
  );

  pmc_mode_reg u_mode (
    .clk(clk), .rst(rst), .wr_ok(wr_ok), .wr_mode(wr_mode),
    .prog_mode(prog_mode)
  );

  pmc_domain_seq u_seq (
    .clk(clk), .rst(rst), .prog_mode(prog_mode), .deep_sleep(core_deep_sleep),
    .applied(applied), .dom(dom), .done(mode_done)
  );

  always_ff @(posedge clk) begin
    if (rst)      bus_rdata <= '0;
    else if (hit) bus_rdata <= {RD_KEY, {PAD_W{1'b0}}, prog_mode};
    else          bus_rdata <= '0;
  end

  assign dom_pwr_en = dom.pwr;
  assign dom_clk_en = dom.clk;
  assign dom_iso_en = dom.iso;
  assign dom_rst    = dom.rst;
  assign dom_ret_en = dom.ret;

  // R3: any non-zero read carries the fixed read-back key and a clean pad
  p_rdata_key_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_rdata != '0) |-> (bus_rdata[DATA_W-1 -: KEY_W] == RD_KEY &&
                           bus_rdata[MODE_W +: PAD_W] == '0));

  // R11: without a new write, a non-retained mode is reached in one edge
  p_done_follow_r11: assert property (@(posedge clk) disable iff (rst)
    (!wr_ok && prog_mode != PM_RET) |=> mode_done);

  // R10: the applied state differs from the programmed one only for a step
  p_applied_valid_r10: assert property (@(posedge clk) disable iff (rst)
    (!wr_ok && applied != prog_mode && prog_mode != PM_RET) |=> (applied == $past(prog_mode)));

endmodule

// File: tb/sim_core_pwr_ctl.sv
module sim_core_pwr_ctl;

  localparam logic [11:0] RA = 12'h200;
  localparam logic [4:0] P_OFF = 5'b00110, P_RST = 5'b10010,
                         P_RET = 5'b00101, P_ON  = 5'b11000;

  logic clk = 1'b0, rst = 1'b1;
  logic [11:0] bus_addr = RA;
  logic bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic ds = 1'b0;
  logic done, pwr, cen, iso, crst, ret;
  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  core_pwr_ctl u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .core_deep_sleep(ds),
    .mode_done(done), .dom_pwr_en(pwr), .dom_clk_en(cen), .dom_iso_en(iso),
    .dom_rst(crst), .dom_ret_en(ret)
  );

  function automatic logic [4:0] domv();
    return {pwr, cen, iso, crst, ret};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // write spanning one edge k; returns at the negedge after k
  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_addr = RA;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    @(negedge clk);
    v = bus_rdata;
    bus_addr = RA;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(RA, v);
    chk("R4 reset read", v, 32'hFA050001);
    chk("R4 reset domain", {27'd0, domv()}, {27'd0, P_RST});
    chk("R4 reset done", {31'd0, done}, 32'd1);
  endtask

  task automatic t_enable();
    logic [31:0] v;
    wr(RA, 32'h05FA0003);
    chk("R11 done low after write", {31'd0, done}, 32'd0);
    chk("R11 domain not yet changed", {27'd0, domv()}, {27'd0, P_RST});
    @(negedge clk);
    chk("R7 enabled pattern", {27'd0, domv()}, {27'd0, P_ON});
    chk("R11 done back high", {31'd0, done}, 32'd1);
    rd(RA, v);
    chk("R1 read enabled", v, 32'hFA050003);
  endtask

  task automatic t_bad_key();
    logic [31:0] v;
    wr(RA, 32'h05FB0000);
    wr(RA, 32'hFA050000);
    wr(RA, 32'h00000000);
    @(negedge clk);
    rd(RA, v);
    chk("R2 wrong key ignored", v, 32'hFA050003);
    chk("R2 wrong key domain", {27'd0, domv()}, {27'd0, P_ON});
  endtask

  task automatic t_bad_addr();
    logic [31:0] v;
    wr(12'h204, 32'h05FA0000);
    @(negedge clk);
    rd(RA, v);
    chk("R2 other address ignored", v, 32'hFA050003);
    chk("R2 other address domain", {27'd0, domv()}, {27'd0, P_ON});
    rd(12'h204, v);
    chk("R3 other address reads zero", v, 32'h0);
  endtask

  task automatic t_off();
    logic [31:0] v;
    wr(RA, 32'h05FAFFFC);
    @(negedge clk);
    chk("R5 off pattern", {27'd0, domv()}, {27'd0, P_OFF});
    rd(RA, v);
    chk("R3 pad reads zero", v, 32'hFA050000);
  endtask

  task automatic t_reset_mode();
    wr(RA, 32'h05FA0001);
    @(negedge clk);
    chk("R6 reset pattern", {27'd0, domv()}, {27'd0, P_RST});
    chk("R6 done", {31'd0, done}, 32'd1);
  endtask

  task automatic t_ret_wait();
    logic [31:0] v;
    ds = 1'b0;
    wr(RA, 32'h05FA0003);
    @(negedge clk);
    wr(RA, 32'h05FA0002);
    repeat (5) @(negedge clk);
    chk("R9 pending domain held", {27'd0, domv()}, {27'd0, P_ON});
    chk("R9 pending done low", {31'd0, done}, 32'd0);
    rd(RA, v);
    chk("R1 read retained", v, 32'hFA050002);
    ds = 1'b1;
    @(negedge clk);
    chk("R8 retained pattern", {27'd0, domv()}, {27'd0, P_RET});
    chk("R8 retained done", {31'd0, done}, 32'd1);
    ds = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 retained kept after wake", {27'd0, domv()}, {27'd0, P_RET});
  endtask

  task automatic t_cancel();
    bit seen_ret = 1'b0;
    ds = 1'b0;
    wr(RA, 32'h05FA0003);
    @(negedge clk);
    wr(RA, 32'h05FA0002);
    repeat (3) begin
      @(negedge clk);
      if (ret) seen_ret = 1'b1;
    end
    wr(RA, 32'h05FA0003);
    if (ret) seen_ret = 1'b1;
    @(negedge clk);
    chk("R10 cancel domain", {27'd0, domv()}, {27'd0, P_ON});
    chk("R10 cancel done", {31'd0, done}, 32'd1);
    chk("R10 retained never shown", {31'd0, seen_ret}, 32'd0);
  endtask

  task automatic t_collide();
    ds = 1'b0;
    wr(RA, 32'h05FA0002);
    @(negedge clk);
    bus_we = 1'b1; bus_wdata = 32'h05FA0003; ds = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; ds = 1'b0;
    chk("R8 collide retained applied", {27'd0, domv()}, {27'd0, P_RET});
    chk("R11 collide done low", {31'd0, done}, 32'd0);
    @(negedge clk);
    chk("R10 collide enabled", {27'd0, domv()}, {27'd0, P_ON});
    chk("R11 collide done high", {31'd0, done}, 32'd1);
  endtask

  task automatic t_ret_direct();
    ds = 1'b1;
    wr(RA, 32'h05FA0002);
    chk("R11 direct done low", {31'd0, done}, 32'd0);
    @(negedge clk);
    chk("R8 direct retained", {27'd0, domv()}, {27'd0, P_RET});
    wr(RA, 32'h05FA0002);
    chk("R11 same mode keeps done", {31'd0, done}, 32'd1);
    ds = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_enable();
    t_bad_key();
    t_bad_addr();
    t_off();
    t_reset_mode();
    t_ret_wait();
    t_cancel();
    t_collide();
    t_ret_direct();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule